// File: doc/BRIEF.md
# Pixel-Parallel SIMD Processor Array

This block is a grid of identical processing elements, one per pixel. Each element holds a few signed data registers and a one-bit enable flag. A controller presents one instruction at a time through a valid/ready handshake. Every element executes an accepted instruction on the same clock edge, using its own registers. Arithmetic covers copy, saturating add, saturating subtract and halving. A neighbour copy lets every element read a register from the element beside it in one of four directions, so one instruction shifts a whole image by one pixel.

Conditional execution uses the flags. A "where" instruction loads each flag from the test of a register. Elements whose flag is clear keep their registers unchanged until an "all" instruction sets every flag again. A cleared element still supplies its values to its neighbours.

Pixels are written and read one element at a time through dedicated ports. Results can also leave the array in compact form. A global instruction reports whether any element holds a nonzero value in a chosen register, together with the signed total of that register. A scan instruction lists the row and column of every element whose chosen register is nonzero, in row-major order.

Top module: `simd_pix_array`

## Requirements
- R1: After reset every register is 0, every flag is set, `ins_ready` is 1, and `glob_valid`, `ev_valid` and `ev_done` are 0.
- R2: Opcode 1 copies register `ins_sa` to `ins_dst`. Opcode 3 writes `ins_sa + ins_sb` to `ins_dst`. Opcode 4 writes `ins_sa - ins_sb` to `ins_dst`. The add and subtract results saturate to the signed W-bit range. All enabled elements update on the accepting edge.
- R3: Opcode 5 writes register `ins_sa` arithmetically shifted right by one to `ins_dst`, so -5 becomes -3.
- R4: Opcode 2 writes the `ins_sa` register of the neighbour named by `ins_dir` into `ins_dst`. The `ins_dir` codes are 0 for north (row-1), 1 for east (col+1), 2 for south (row+1) and 3 for west (col-1). A neighbour outside the grid reads as 0.
- R5: Opcode 6 sets each flag to (register `ins_sa` != 0). While an element's flag is clear, opcodes 1 to 5 leave its registers unchanged. Opcode 7 sets every flag.
- R6: An element with a clear flag still supplies its current register values to opcode 2 in enabled neighbours.
- R7: Opcode 8 on register `ins_sa` makes `glob_valid` high for exactly the one cycle after the accepting edge. In that cycle `glob_or` is 1 if any element's register is nonzero, and `glob_sum` is the signed sum of that register over all elements, whatever their flags.
- R8: Opcode 9 on register `ins_sa` emits, from the edge after acceptance, the row and column of each element with a nonzero register. The addresses come in row-major order, one per cycle, each with `ev_valid`. `ev_done` pulses for one cycle after the last address, or one cycle after acceptance when no element qualifies.
- R9: `ins_ready` is low while a scan is in progress.
- R10: When `pix_we` is high, register `pix_reg` of element (`pix_row`, `pix_col`) takes `pix_data` whatever its flag, and `ins_ready` is low. `rd_data` always shows register `rd_reg` of element (`rd_row`, `rd_col`) combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Instruction can be accepted |
| ins_op | input | 4 | Opcode (0 no-op, 1 copy, 2 neighbour copy, 3 add, 4 subtract, 5 halve, 6 where, 7 all, 8 global, 9 scan) |
| ins_dst | input | $clog2(NREG) | Destination register |
| ins_sa | input | $clog2(NREG) | First source register |
| ins_sb | input | $clog2(NREG) | Second source register |
| ins_dir | input | 2 | Neighbour direction |
| pix_we | input | 1 | Pixel write strobe |
| pix_row | input | $clog2(ROWS) | Write row |
| pix_col | input | $clog2(COLS) | Write column |
| pix_reg | input | $clog2(NREG) | Write register |
| pix_data | input | W | Write value |
| rd_row | input | $clog2(ROWS) | Read row |
| rd_col | input | $clog2(COLS) | Read column |
| rd_reg | input | $clog2(NREG) | Read register |
| rd_data | output | W | Read value |
| glob_valid | output | 1 | Global result strobe |
| glob_or | output | 1 | Any element nonzero |
| glob_sum | output | W+$clog2(ROWS*COLS) | Signed array total |
| ev_valid | output | 1 | Scan address strobe |
| ev_row | output | $clog2(ROWS) | Scan row |
| ev_col | output | $clog2(COLS) | Scan column |
| ev_done | output | 1 | Scan finished |

## Verification
Some properties are checked on every cycle. The global result always appears exactly one cycle after its instruction and at no other time. Scan addresses stay inside the grid, and `ev_done` never coincides with an address. The handshake stays closed while a scan is running. An element with a clear flag keeps its registers through arithmetic instructions, and "all" re-enables it.

Other behaviour needs the bench's scenarios. These include saturated and halved values, the effect of each neighbour direction at the grid edges, and masked elements feeding their neighbours. They also include the exact global totals and the full row-major address lists. These depend on the contents of the whole array, so the bench compares them against its own model.

// File: rtl/simd_pix_array.sv
module simd_pix_array #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int W    = 8,
  parameter int NREG = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  ins_valid,
  output logic                                  ins_ready,
  input  logic [3:0]                            ins_op,
  input  logic [$clog2(NREG)-1:0]               ins_dst,
  input  logic [$clog2(NREG)-1:0]               ins_sa,
  input  logic [$clog2(NREG)-1:0]               ins_sb,
  input  logic [1:0]                            ins_dir,
  input  logic                                  pix_we,
  input  logic [$clog2(ROWS)-1:0]               pix_row,
  input  logic [$clog2(COLS)-1:0]               pix_col,
  input  logic [$clog2(NREG)-1:0]               pix_reg,
  input  logic [W-1:0]                          pix_data,
  input  logic [$clog2(ROWS)-1:0]               rd_row,
  input  logic [$clog2(COLS)-1:0]               rd_col,
  input  logic [$clog2(NREG)-1:0]               rd_reg,
  output logic [W-1:0]                          rd_data,
  output logic                                  glob_valid,
  output logic                                  glob_or,
  output logic [W+$clog2(ROWS*COLS)-1:0]        glob_sum,
  output logic                                  ev_valid,
  output logic [$clog2(ROWS)-1:0]               ev_row,
  output logic [$clog2(COLS)-1:0]               ev_col,
  output logic                                  ev_done
);
  localparam int RB   = $clog2(NREG);
  localparam int RW   = $clog2(ROWS);
  localparam int CW   = $clog2(COLS);
  localparam int NPIX = ROWS * COLS;
  localparam int IW   = $clog2(NPIX);
  localparam int SW   = W + IW;

  localparam logic [3:0] OP_MOV  = 4'd1;
  localparam logic [3:0] OP_MOVN = 4'd2;
  localparam logic [3:0] OP_ADD  = 4'd3;
  localparam logic [3:0] OP_SUB  = 4'd4;
  localparam logic [3:0] OP_HALF = 4'd5;
  localparam logic [3:0] OP_WHER = 4'd6;
  localparam logic [3:0] OP_ALL  = 4'd7;
  localparam logic [3:0] OP_GLOB = 4'd8;
  localparam logic [3:0] OP_SCAN = 4'd9;

  logic signed [W-1:0] regs [ROWS][COLS][NREG];
  logic [NPIX-1:0]     flags;
  logic [NPIX*W-1:0]   alu_flat;
  logic [NREG*W-1:0]   e00_bits;

  logic          busy;
  logic [RB-1:0] scan_reg;
  logic [IW:0]   pos;
  logic [NPIX-1:0] actv;
  logic          hit;
  logic [IW-1:0] nxt;

  logic          fire, arith;
  logic          any_nz;
  logic [SW-1:0] tot;

  assign ins_ready = !busy && !pix_we;
  assign fire      = ins_valid && ins_ready;
  assign arith     = (ins_op >= OP_MOV) && (ins_op <= OP_HALF);
  assign rd_data   = regs[rd_row][rd_col][rd_reg];

  function automatic logic signed [W-1:0] clamp(input logic signed [W:0] s);
    if (s[W] != s[W-1]) return s[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    return s[W-1:0];
  endfunction

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int RN = (r > 0) ? r - 1 : 0;
      localparam int RS = (r < ROWS - 1) ? r + 1 : r;
      localparam int CE = (c < COLS - 1) ? c + 1 : c;
      localparam int CL = (c > 0) ? c - 1 : 0;
      logic signed [W-1:0] a, b, nb, v;
      logic signed [W:0]   s_add, s_sub;
      assign a     = regs[r][c][ins_sa];
      assign b     = regs[r][c][ins_sb];
      assign s_add = {a[W-1], a} + {b[W-1], b};
      assign s_sub = {a[W-1], a} - {b[W-1], b};
      always_comb begin
        case (ins_dir)
          2'd0:    nb = (r > 0)        ? regs[RN][c][ins_sa] : '0;
          2'd1:    nb = (c < COLS - 1) ? regs[r][CE][ins_sa] : '0;
          2'd2:    nb = (r < ROWS - 1) ? regs[RS][c][ins_sa] : '0;
          default: nb = (c > 0)        ? regs[r][CL][ins_sa] : '0;
        endcase
        case (ins_op)
          OP_MOVN: v = nb;
          OP_ADD:  v = clamp(s_add);
          OP_SUB:  v = clamp(s_sub);
          OP_HALF: v = a >>> 1;
          default: v = a;
        endcase
      end
      assign alu_flat[(r*COLS+c)*W +: W] = v;
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_e00
    assign e00_bits[k*W +: W] = regs[0][0][k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          for (int k = 0; k < NREG; k++)
            regs[r][c][k] <= '0;
      flags <= '1;
    end else begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          if (pix_we && pix_row == RW'(r) && pix_col == CW'(c))
            regs[r][c][pix_reg] <= pix_data;
          else if (fire && arith && flags[r*COLS+c])
            regs[r][c][ins_dst] <= alu_flat[(r*COLS+c)*W +: W];
          if (fire && ins_op == OP_WHER) flags[r*COLS+c] <= |regs[r][c][ins_sa];
        end
      if (fire && ins_op == OP_ALL) flags <= '1;
    end
  end

  always_comb begin
    any_nz = 1'b0;
    tot    = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        any_nz = any_nz | (|regs[r][c][ins_sa]);
        tot    = tot + {{(SW-W){regs[r][c][ins_sa][W-1]}}, regs[r][c][ins_sa]};
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_valid <= 1'b0;
      glob_or    <= 1'b0;
      glob_sum   <= '0;
    end else begin
      glob_valid <= fire && ins_op == OP_GLOB;
      if (fire && ins_op == OP_GLOB) begin
        glob_or  <= any_nz;
        glob_sum <= tot;
      end
    end
  end

  always_comb begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        actv[r*COLS+c] = |regs[r][c][scan_reg];
    hit = 1'b0;
    nxt = '0;
    for (int i = NPIX - 1; i >= 0; i--)
      if (actv[i] && (IW+1)'(i) >= pos) begin
        hit = 1'b1;
        nxt = IW'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      scan_reg <= '0;
      pos      <= '0;
      ev_valid <= 1'b0;
      ev_done  <= 1'b0;
      ev_row   <= '0;
      ev_col   <= '0;
    end else begin
      ev_valid <= 1'b0;
      ev_done  <= 1'b0;
      if (busy) begin
        if (hit) begin
          ev_valid <= 1'b1;
          ev_row   <= RW'(int'(nxt) / COLS);
          ev_col   <= CW'(int'(nxt) % COLS);
          pos      <= (IW+1)'(nxt) + (IW+1)'(1);
        end else begin
          ev_done <= 1'b1;
          busy    <= 1'b0;
        end
      end else if (fire && ins_op == OP_SCAN) begin
        busy     <= 1'b1;
        scan_reg <= ins_sa;
        pos      <= '0;
      end
    end
  end
endmodule

module simd_pix_array_chk #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int W    = 8,
  parameter int NREG = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ins_valid,
  input logic                    ins_ready,
  input logic [3:0]              ins_op,
  input logic                    glob_valid,
  input logic                    ev_valid,
  input logic                    ev_done,
  input logic [$clog2(ROWS)-1:0] ev_row,
  input logic [$clog2(COLS)-1:0] ev_col,
  input logic                    flag00,
  input logic [NREG*W-1:0]       e00
);
  logic acc;
  assign acc = ins_valid && ins_ready;

  a_r7_glob_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ins_op == 4'd8) |=> glob_valid);
  a_r7_glob_only_after: assert property (@(posedge clk) disable iff (!rst_n)
    glob_valid |-> $past(acc && ins_op == 4'd8));
  a_r8_addr_in_grid: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (32'(ev_row) < ROWS && 32'(ev_col) < COLS));
  a_r8_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |-> !ev_valid);
  a_r9_closed_while_scanning: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !ins_ready);
  a_r5_masked_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ins_op >= 4'd1 && ins_op <= 4'd5 && !flag00) |=> $stable(e00));
  a_r5_all_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ins_op == 4'd7) |=> flag00);
endmodule

bind simd_pix_array simd_pix_array_chk #(.ROWS(ROWS), .COLS(COLS), .W(W), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_op(ins_op),
  .glob_valid(glob_valid), .ev_valid(ev_valid), .ev_done(ev_done), .ev_row(ev_row),
  .ev_col(ev_col), .flag00(flags[0]), .e00(e00_bits)
);

// File: tb/tb_simd_pix_array.sv
module tb_simd_pix_array;
  localparam int ROWS = 4, COLS = 4, W = 8, NREG = 4;

  logic clk = 0, rst_n = 0;
  logic ins_valid = 0, ins_ready;
  logic [3:0] ins_op = 0;
  logic [1:0] ins_dst = 0, ins_sa = 0, ins_sb = 0, ins_dir = 0;
  logic pix_we = 0;
  logic [1:0] pix_row = 0, pix_col = 0, pix_reg = 0;
  logic [7:0] pix_data = 0;
  logic [1:0] rd_row = 0, rd_col = 0, rd_reg = 0;
  logic [7:0] rd_data;
  logic glob_valid, glob_or;
  logic [11:0] glob_sum;
  logic ev_valid, ev_done;
  logic [1:0] ev_row, ev_col;

  simd_pix_array #(.ROWS(ROWS), .COLS(COLS), .W(W), .NREG(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_op(ins_op),
    .ins_dst(ins_dst), .ins_sa(ins_sa), .ins_sb(ins_sb), .ins_dir(ins_dir),
    .pix_we(pix_we), .pix_row(pix_row), .pix_col(pix_col), .pix_reg(pix_reg), .pix_data(pix_data),
    .rd_row(rd_row), .rd_col(rd_col), .rd_reg(rd_reg), .rd_data(rd_data),
    .glob_valid(glob_valid), .glob_or(glob_or), .glob_sum(glob_sum),
    .ev_valid(ev_valid), .ev_row(ev_row), .ev_col(ev_col), .ev_done(ev_done));

  always #10 clk = ~clk;

  int total = 0, bad = 0, done_cnt = 0;
  int mdl [ROWS][COLS][NREG];
  bit mf [ROWS][COLS];
  int exp_ev[$];
  int exp_glob[$];
  string ev_tag = "R8";

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (ev_valid) begin
      if (exp_ev.size() == 0) chk({ev_tag, " unexpected address"}, ev_row * COLS + ev_col, -1);
      else chk({ev_tag, " address order"}, ev_row * COLS + ev_col, exp_ev.pop_front());
    end
    if (glob_valid) begin
      if (exp_glob.size() < 2) chk("R7 unexpected global", 1, 0);
      else begin
        chk("R7 global or", int'(glob_or), exp_glob.pop_front());
        chk("R7 global sum", int'($signed(glob_sum)), exp_glob.pop_front());
      end
    end
    if (ev_done) done_cnt++;
  end

  function automatic int sat(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic pix(int r, int c, int k, int v);
    @(negedge clk);
    pix_we = 1; pix_row = 2'(r); pix_col = 2'(c); pix_reg = 2'(k); pix_data = 8'(v);
    #1 chk("R10 ready low during write", int'(ins_ready), 0);
    @(posedge clk);
    @(negedge clk);
    pix_we = 0;
    mdl[r][c][k] = sat(v);
  endtask

  task automatic exec(int op, int d, int a, int b, int dir);
    int nv [ROWS][COLS];
    @(negedge clk);
    while (!ins_ready) @(negedge clk);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int nr = r, nc = c, n;
        if (dir == 0) nr = r - 1; else if (dir == 1) nc = c + 1;
        else if (dir == 2) nr = r + 1; else nc = c - 1;
        n = (nr < 0 || nr >= ROWS || nc < 0 || nc >= COLS) ? 0 : mdl[nr][nc][a];
        case (op)
          1: nv[r][c] = mdl[r][c][a];
          2: nv[r][c] = n;
          3: nv[r][c] = sat(mdl[r][c][a] + mdl[r][c][b]);
          4: nv[r][c] = sat(mdl[r][c][a] - mdl[r][c][b]);
          5: nv[r][c] = mdl[r][c][a] >>> 1;
          default: nv[r][c] = 0;
        endcase
      end
    if (op == 8) begin
      int o = 0, s = 0;
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          if (mdl[r][c][a] != 0) o = 1;
          s += mdl[r][c][a];
        end
      exp_glob.push_back(o);
      exp_glob.push_back(s);
    end
    if (op == 9)
      for (int i = 0; i < ROWS * COLS; i++)
        if (mdl[i / COLS][i % COLS][a] != 0) exp_ev.push_back(i);
    ins_valid = 1; ins_op = 4'(op); ins_dst = 2'(d); ins_sa = 2'(a); ins_sb = 2'(b); ins_dir = 2'(dir);
    @(posedge clk);
    @(negedge clk);
    ins_valid = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        if (op >= 1 && op <= 5 && mf[r][c]) mdl[r][c][d] = nv[r][c];
        if (op == 6) mf[r][c] = (mdl[r][c][a] != 0);
        if (op == 7) mf[r][c] = 1;
      end
  endtask

  task automatic check_all(string req);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        for (int k = 0; k < NREG; k++) begin
          rd_row = 2'(r); rd_col = 2'(c); rd_reg = 2'(k);
          #1 chk(req, int'($signed(rd_data)), mdl[r][c][k]);
        end
  endtask

  task automatic wait_done(string req);
    int start = done_cnt;
    int n = 0;
    while (done_cnt == start && n < 200) begin @(negedge clk); n++; end
    chk({req, " done seen"}, int'(done_cnt > start), 1);
    chk({req, " all addresses seen"}, exp_ev.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        mf[r][c] = 1;
        for (int k = 0; k < NREG; k++) mdl[r][c][k] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", int'(ins_ready), 1);
    chk("R1 glob_valid", int'(glob_valid), 0);
    chk("R1 ev_valid", int'(ev_valid), 0);
    chk("R1 ev_done", int'(ev_done), 0);
    check_all("R1 registers zero");

    for (int i = 0; i < ROWS * COLS; i++) pix(i / COLS, i % COLS, 0, i - 5);
    for (int i = 0; i < ROWS * COLS; i++) pix(i / COLS, i % COLS, 2, 125);
    check_all("R10 pixel load");

    exec(1, 1, 0, 0, 0); check_all("R2 copy");
    exec(3, 3, 0, 2, 0); check_all("R2 add saturates high");
    exec(4, 3, 1, 2, 0); check_all("R2 sub saturates low");
    exec(5, 3, 0, 0, 0); check_all("R3 halve");
    for (int d = 0; d < 4; d++) begin
      exec(2, 1, 0, 0, d);
      check_all("R4 neighbour move");
    end

    exec(6, 3, 3, 0, 0);
    exec(1, 1, 2, 0, 0); check_all("R5 masked copy");
    exec(2, 1, 2, 0, 1); check_all("R6 masked neighbour source");
    rd_row = 1; rd_col = 0; rd_reg = 1;
    #1 chk("R6 element (1,0) from masked east", int'($signed(rd_data)), 125);
    pix(1, 1, 3, 42);
    rd_row = 1; rd_col = 1; rd_reg = 3;
    #1 chk("R10 write to masked element", int'($signed(rd_data)), 42);
    exec(7, 0, 0, 0, 0);
    exec(1, 1, 0, 0, 0); check_all("R5 all re-enables");

    exec(8, 0, 0, 0, 0);
    exec(8, 0, 2, 0, 0);
    exec(4, 3, 0, 0, 0);
    exec(8, 0, 3, 0, 0);
    @(negedge clk);
    chk("R7 scoreboard drained", exp_glob.size(), 0);

    exec(9, 0, 0, 0, 0);
    chk("R9 ready low in scan", int'(ins_ready), 0);
    wait_done("R8 dense scan");
    exec(9, 0, 3, 0, 0);
    chk("R9 ready low in empty scan", int'(ins_ready), 0);
    wait_done("R8 empty scan");
    pix(3, 3, 3, 1);
    pix(0, 2, 3, -1);
    exec(9, 0, 3, 0, 0);
    wait_done("R8 sparse scan");
    @(negedge clk);
    chk("R9 ready after scan", int'(ins_ready), 1);
    finish_up();
  end
endmodule